// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches an N-bit word carried on two wires per bit and reports when the whole word has arrived and when the whole word has been withdrawn. Each wire pair holds one of four codes, written here as {one-rail, zero-rail}. The code 00 is the empty spacer. The code 01 carries a logic 0, and the code 10 carries a logic 1. The code 11 is illegal.

The OR of the two wires of a pair marks that bit as present. The presence flags feed a balanced tree of two-input Muller C-elements. Each C-element is a clocked state element that copies its inputs only when both agree and otherwise keeps its value. The root of the tree is the done flag. Because every node has hysteresis, done stays low until every bit is present and stays high until every bit has returned to spacer.

A pipeline stage uses done as its completion event and reads the decoded word while done is high. A sticky flag records any illegal pair seen since reset.

Top module: `dr_completion_detector`

## Requirements
- R1: While rst_ni is low, and at the first sample after reset is released, done_o is 0 and illegal_o is 0.
- R2: A pair is written as {rail1_i[k], rail0_i[k]}. The code 00 is spacer, 01 is logic 0 and 10 is logic 1. Bit k counts as present when rail1_i[k] OR rail0_i[k] is 1, so an illegal 11 pair also counts as present.
- R3: Every C-element node updates at a clock edge. When its two inputs are equal it takes their value, and when they differ it keeps its previous value.
- R4: The tree has L = max(1, ceil(log2 N)) levels, with every leaf at depth L. Once all N bits are present and held, done_o is still 0 after L-1 clock edges and is 1 after L clock edges.
- R5: Once all N bits are spacer and held while done_o is 1, done_o is still 1 after L-1 clock edges and is 0 after L clock edges.
- R6: While done_o is 0, any word with at least one bit present and at least one bit spacer, held for any number of cycles, leaves done_o at 0.
- R7: While done_o is 1, any word with at least one bit still present, held for any number of cycles, leaves done_o at 1.
- R8: data_o[k] equals rail1_i[k], so while done_o is 1 under legal codes data_o is the decoded word.
- R9: A pair with code 11 on any bit sets illegal_o at the next clock edge. illegal_o then stays 1 until rst_ni is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rail1_i | input | N | One-rail wire of each pair |
| rail0_i | input | N | Zero-rail wire of each pair |
| done_o | output | 1 | Completion flag from the C-element tree root |
| data_o | output | N | Decoded word, valid while done_o is 1 |
| illegal_o | output | 1 | Sticky flag for a pair with code 11 |

## Verification
The assertions check three things on every cycle. Each C-element holds its value on disagreeing inputs and follows its inputs when they agree. The done flag is forced to 1 after L consecutive cycles of a fully present word, and forced to 0 after L consecutive cycles of a fully cleared word. The illegal flag never drops outside reset.

The exact L-edge latency in both directions needs the bench's scenarios to show it. The same holds for immunity to partially arrived or partially withdrawn words, the decoded word, and the clearing of the sticky flag by reset.

// File: rtl/dr_pkg.sv
package dr_pkg;
  // Tree depth: every leaf at the same depth, at least one level
  function automatic int tree_levels(input int n);
    int l;
    l = $clog2(n);
    return (l < 1) ? 1 : l;
  endfunction
endpackage

// File: rtl/dr_c_element.sv
module dr_c_element (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic q_o
);
  logic q_q;

  // Majority of a, b and the fed-back state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= (a_i & b_i) | (q_q & (a_i | b_i));
  end

  assign q_o = q_q;

  a_r3_hold_on_disagree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i != b_i) |=> (q_o == $past(q_o)));

  a_r3_follow_on_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i == b_i) |=> (q_o == $past(a_i)));
endmodule

// File: rtl/dr_pair_decode.sv
module dr_pair_decode #(
  parameter int N = 8
) (
  input  logic [N-1:0] rail1_i,
  input  logic [N-1:0] rail0_i,
  output logic [N-1:0] present_o,
  output logic [N-1:0] value_o,
  output logic         any_illegal_o
);
  logic [N-1:0] illegal;

  for (genvar k = 0; k < N; k++) begin : g_pair
    assign present_o[k] = rail1_i[k] | rail0_i[k];
    assign value_o[k]   = rail1_i[k];
    assign illegal[k]   = rail1_i[k] & rail0_i[k];
  end

  assign any_illegal_o = |illegal;
endmodule

// File: rtl/dr_c_tree.sv
module dr_c_tree #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] leaf_i,
  output logic         root_o
);
  localparam int L = dr_pkg::tree_levels(N);
  localparam int P = 1 << L;

  // Heap layout: nodes 1..P-1 internal, P..2P-1 leaves
  logic [2*P-1:1] node;

  for (genvar j = 0; j < P; j++) begin : g_leaf
    if (j < N) begin : g_real
      assign node[P+j] = leaf_i[j];
    end else begin : g_pad
      // Padding leaf mirrors bit 0 so it never blocks agreement
      assign node[P+j] = leaf_i[0];
    end
  end

  for (genvar i = 1; i < P; i++) begin : g_node
    dr_c_element u_c (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .a_i    (node[2*i]),
      .b_i    (node[2*i+1]),
      .q_o    (node[i])
    );
  end

  assign root_o = node[1];
endmodule

// File: rtl/dr_completion_detector.sv
module dr_completion_detector #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] rail1_i,
  input  logic [N-1:0] rail0_i,
  output logic         done_o,
  output logic [N-1:0] data_o,
  output logic         illegal_o
);
  localparam int L  = dr_pkg::tree_levels(N);
  localparam int RW = $clog2(L + 1);

  logic [N-1:0] present;
  logic         any_illegal;
  logic         err_q;

  dr_pair_decode #(.N(N)) u_dec (
    .rail1_i       (rail1_i),
    .rail0_i       (rail0_i),
    .present_o     (present),
    .value_o       (data_o),
    .any_illegal_o (any_illegal)
  );

  dr_c_tree #(.N(N)) u_tree (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .leaf_i (present),
    .root_o (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q | any_illegal;
  end

  assign illegal_o = err_q;

  // Checker: runs of full / empty words, saturating at L
  logic [RW-1:0] full_run_q, empty_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_run_q  <= '0;
      empty_run_q <= '0;
    end else begin
      if (&present) full_run_q <= (full_run_q == RW'(L)) ? full_run_q : full_run_q + 1'b1;
      else          full_run_q <= '0;
      if (~|present) empty_run_q <= (empty_run_q == RW'(L)) ? empty_run_q : empty_run_q + 1'b1;
      else           empty_run_q <= '0;
    end
  end

  a_r4_full_forces_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_run_q == RW'(L)) |-> done_o);

  a_r5_empty_forces_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_run_q == RW'(L)) |-> !done_o);

  a_r9_illegal_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o);

  a_r9_illegal_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_illegal |=> illegal_o);
endmodule

// File: tb/dr_completion_detector_bench.sv
module dr_completion_detector_bench;
  localparam int N = 8;
  localparam int L = ($clog2(N) < 1) ? 1 : $clog2(N);

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] rail1_i = '0;
  logic [N-1:0] rail0_i = '0;
  logic         done_o;
  logic [N-1:0] data_o;
  logic         illegal_o;

  int tests = 0;
  int fails = 0;

  always #2 clk_i = ~clk_i;

  dr_completion_detector #(.N(N)) u_dr_completion_detector (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rail1_i   (rail1_i),
    .rail0_i   (rail0_i),
    .done_o    (done_o),
    .data_o    (data_o),
    .illegal_o (illegal_o)
  );

  function automatic logic [N-1:0] enc1(input logic [N-1:0] w, input logic [N-1:0] m);
    return w & m;
  endfunction
  function automatic logic [N-1:0] enc0(input logic [N-1:0] w, input logic [N-1:0] m);
    return ~w & m;
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] w, input logic [N-1:0] m);
    rail1_i = enc1(w, m);
    rail0_i = enc0(w, m);
  endtask

  task automatic wait_edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // Full word arrival: R4 latency, R8 data
  task automatic arrive(input logic [N-1:0] w);
    drive(w, '1);
    if (L > 1) begin
      wait_edges(L - 1);
      chk("R4 done early", N'(done_o), N'(1'b0));
      wait_edges(1);
    end else wait_edges(L);
    chk("R4 done after L", N'(done_o), N'(1'b1));
    chk("R8 data", data_o, w);
    chk("R2 one-rail decode", data_o, rail1_i);
  endtask

  task automatic withdraw();
    drive('0, '0);
    if (L > 1) begin
      wait_edges(L - 1);
      chk("R5 done still high", N'(done_o), N'(1'b1));
      wait_edges(1);
    end else wait_edges(L);
    chk("R5 done cleared", N'(done_o), N'(1'b0));
  endtask

  initial begin
    int seed_dummy;
    logic [N-1:0] w, m;
    seed_dummy = $urandom(32'h5eed_1234);

    // R1 reset
    wait_edges(3);
    chk("R1 done in reset", N'(done_o), N'(1'b0));
    chk("R1 illegal in reset", N'(illegal_o), N'(1'b0));
    rst_ni = 1'b1;
    wait_edges(1);
    chk("R1 done after reset", N'(done_o), N'(1'b0));
    chk("R1 illegal after reset", N'(illegal_o), N'(1'b0));

    // Directed corners: all zeros, all ones
    arrive('0);
    withdraw();
    arrive('1);
    withdraw();

    // R6: partial arrival (all but bit N-1), then completes
    drive('1, {1'b0, {(N-1){1'b1}}});
    wait_edges(L + 4);
    chk("R6 partial arrival", N'(done_o), N'(1'b0));
    arrive(8'hA5);
    // R7: partial withdrawal leaving only bit 0
    drive(8'hA5, {{(N-1){1'b0}}, 1'b1});
    wait_edges(L + 4);
    chk("R7 partial withdrawal", N'(done_o), N'(1'b1));
    withdraw();

    // R3: single-bit staggered arrival keeps done low until last bit
    m = '0;
    for (int k = 0; k < N - 1; k++) begin
      m[k] = 1'b1;
      drive(8'h3C, m);
      wait_edges(2);
      chk("R3 staggered arrival holds", N'(done_o), N'(1'b0));
    end
    arrive(8'h3C);
    withdraw();

    // Random mix
    for (int it = 0; it < 40; it++) begin
      w = N'($urandom);
      m = N'($urandom);
      if (m != '0 && m != '1) begin
        drive(w, m);
        wait_edges(L + 1 + ($urandom % 4));
        chk("R6 random partial", N'(done_o), N'(1'b0));
      end
      arrive(w);
      m = N'($urandom);
      if (m != '0) begin
        drive(w, m);
        wait_edges(L + 1 + ($urandom % 4));
        chk("R7 random partial", N'(done_o), N'(1'b1));
      end
      withdraw();
      chk("R9 no false illegal", N'(illegal_o), N'(1'b0));
    end

    // R9: illegal code 11 on bit 2
    rail1_i = 8'h04;
    rail0_i = 8'h04;
    #1;
    chk("R9 not before edge", N'(illegal_o), N'(1'b0));
    wait_edges(1);
    chk("R9 set after edge", N'(illegal_o), N'(1'b1));
    drive('0, '0);
    wait_edges(L + 3);
    chk("R9 sticky", N'(illegal_o), N'(1'b1));
    arrive(8'h5A);
    chk("R9 sticky through valid word", N'(illegal_o), N'(1'b1));
    withdraw();

    // R2: illegal pair counts as present for completion
    rail1_i = 8'hFF;
    rail0_i = 8'h01;
    wait_edges(L);
    chk("R2 illegal counts present", N'(done_o), N'(1'b1));
    withdraw();

    // R1/R9: reset clears flag
    rst_ni = 1'b0;
    wait_edges(2);
    rst_ni = 1'b1;
    wait_edges(1);
    chk("R9 cleared by reset", N'(illegal_o), N'(1'b0));
    arrive(8'h96);
    chk("R9 stays clear", N'(illegal_o), N'(1'b0));
    withdraw();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule